// File: doc/BRIEF.md
# Stepper Stall Detection Sequencer

This block decides whether a stepper motor's pointer has reached its mechanical end stop, without a position sensor. On a start command it takes one full step: one coil is powered with a chosen polarity and the other coil is left floating. After a blanking interval lets the coil current settle, it integrates a 1-bit sigma-delta stream. That stream is the digitised back-EMF induced in the floating coil.

A single down counter times both windows. The counter is first loaded with the blanking count and then reloaded with the integration count. A saturating signed accumulator sums the stream, counting +1 for each one and -1 for each zero. When integration ends, the sum is compared with a signed threshold. A sum at or below the threshold means the rotor did not move, and the block reports a stall. The sum stays readable until the next measurement starts.

Homing firmware runs the block repeatedly. Between runs it chooses the coil and the polarity, which walks the pointer clockwise or counter-clockwise. It stops stepping when a stall is reported. The analog integrator and the modulator are outside this block.

Top module: `stall_seq`

## Requirements
- R1: When the block is idle, `start_i` high with `abort_i` low begins a measurement. `busy_o` is high from the next cycle, and the accumulator reads 0 during blanking.
- R2: During blanking and integration, the coil selected by `coil_sel_i` is driven (0 selects coil A, 1 selects coil B). The drive code is 2'b01 when `pol_i` is 1 and 2'b10 when `pol_i` is 0. The other coil reads 2'b00, which means undriven. At all other times both coils read 2'b00.
- R3: With blanking count B and integration count N, blanking lasts B+1 cycles and integration samples `bit_i` on N+1 consecutive edges. Counting the start edge as edge 0, `done_o` rises after edge B+N+3, and `busy_o` stays high until then.
- R4: The accumulator adds +1 for each sampled 1 and -1 for each sampled 0. Its value appears on `acc_o` and holds from the end of integration until the next accepted start.
- R5: The accumulator saturates at +32767 and -32768 instead of wrapping.
- R6: At the decision, `stall_o` becomes 1 when the signed sum is less than or equal to the signed threshold `thresh_i`, and 0 otherwise. An equal value counts as a stall. `stall_o` holds until the next decision.
- R7: `done_o` is a one-cycle pulse, and `busy_o` is low in the cycle where it is high.
- R8: A start request while busy is ignored. The coil, polarity, counts and threshold are captured at the accepted start, so changes to them during a run have no effect on it.
- R9: `abort_i` returns the block to idle on the next edge with both coils undriven and no `done_o` pulse. It takes priority over a simultaneous start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one measurement |
| abort_i | input | 1 | Cancel any measurement |
| coil_sel_i | input | 1 | Coil to power: 0 for A, 1 for B |
| pol_i | input | 1 | Drive polarity: 1 positive, 0 negative |
| blank_cnt_i | input | 16 | Blanking count B |
| integ_cnt_i | input | 16 | Integration count N |
| thresh_i | input | 16 | Signed stall threshold |
| bit_i | input | 1 | Sigma-delta back-EMF bit |
| coil_a_o | output | 2 | Coil A drive code |
| coil_b_o | output | 2 | Coil B drive code |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle completion pulse |
| stall_o | output | 1 | 1 means stalled, 0 means moving |
| acc_o | output | 16 | Signed integration sum |

## Verification
A start and an abort can arrive in the same cycle. The bench raises both together while the block is idle, then checks that `busy_o` stays low and both coils stay undriven. A start can also coincide with the completion pulse. The bench raises `start_i` in the cycle where `done_o` is high and expects a new run to begin on the next edge, because the block is already idle then. Starts are also injected in the middle of runs with altered settings, and the bench confirms that the drive codes, timing and result still follow the settings captured at the original start.

// File: rtl/stall_seq_pkg.sv
package stall_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BLANK  = 2'd1,
        ST_INTEG  = 2'd2,
        ST_DECIDE = 2'd3
    } seq_state_e;

    localparam logic [1:0] DRV_OFF = 2'b00;
    localparam logic [1:0] DRV_POS = 2'b01;
    localparam logic [1:0] DRV_NEG = 2'b10;
endpackage

// File: rtl/stall_sat_accum.sv
module stall_sat_accum #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

    logic [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            acc_d = '0;
        end else if (en_i) begin
            if (bit_i && (acc_q != ACC_MAX)) begin
                acc_d = acc_q + ONE;
            end else if (!bit_i && (acc_q != ACC_MIN)) begin
                acc_d = acc_q - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/stall_coil_map.sv
module stall_coil_map
    import stall_seq_pkg::*;
(
    input  logic       active_i,
    input  logic       sel_i,
    input  logic       pol_i,
    output logic [1:0] coil_a_o,
    output logic [1:0] coil_b_o
);
    logic [1:0] code;

    always_comb begin
        code     = pol_i ? DRV_POS : DRV_NEG;
        coil_a_o = DRV_OFF;
        coil_b_o = DRV_OFF;
        if (active_i) begin
            if (sel_i) coil_b_o = code;
            else       coil_a_o = code;
        end
    end
endmodule

// File: rtl/stall_seq.sv
module stall_seq
    import stall_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             coil_sel_i,
    input  logic             pol_i,
    input  logic [CNT_W-1:0] blank_cnt_i,
    input  logic [CNT_W-1:0] integ_cnt_i,
    input  logic [ACC_W-1:0] thresh_i,
    input  logic             bit_i,
    output logic [1:0]       coil_a_o,
    output logic [1:0]       coil_b_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             stall_o,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] integ;
        logic [ACC_W-1:0] thr;
        logic             sel;
        logic             pol;
        logic             done;
        logic             stall;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic acc_clr, acc_en;
    logic [ACC_W-1:0] acc_w;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        acc_clr    = 1'b0;
        acc_en     = 1'b0;
        if (abort_i) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.cnt = '0;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (start_i) begin
                        ctl_d.st    = ST_BLANK;
                        ctl_d.cnt   = blank_cnt_i;
                        ctl_d.integ = integ_cnt_i;
                        ctl_d.thr   = thresh_i;
                        ctl_d.sel   = coil_sel_i;
                        ctl_d.pol   = pol_i;
                        acc_clr     = 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d.st  = ST_INTEG;
                        ctl_d.cnt = ctl_q.integ;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - CNT_ONE;
                    end
                end
                ST_INTEG: begin
                    acc_en = 1'b1;
                    if (ctl_q.cnt == '0) ctl_d.st = ST_DECIDE;
                    else                 ctl_d.cnt = ctl_q.cnt - CNT_ONE;
                end
                ST_DECIDE: begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.done  = 1'b1;
                    ctl_d.stall = ($signed(acc_w) <= $signed(ctl_q.thr));
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    stall_sat_accum #(.ACC_W(ACC_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (acc_clr),
        .en_i  (acc_en),
        .bit_i (bit_i),
        .acc_o (acc_w)
    );

    stall_coil_map u_coils (
        .active_i ((ctl_q.st == ST_BLANK) || (ctl_q.st == ST_INTEG)),
        .sel_i    (ctl_q.sel),
        .pol_i    (ctl_q.pol),
        .coil_a_o (coil_a_o),
        .coil_b_o (coil_b_o)
    );

    assign busy_o  = (ctl_q.st != ST_IDLE);
    assign done_o  = ctl_q.done;
    assign stall_o = ctl_q.stall;
    assign acc_o   = acc_w;
endmodule

// File: rtl/stall_seq_chk.sv
module stall_seq_chk #(
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             abort_i,
    input logic [1:0]       coil_a_o,
    input logic [1:0]       coil_b_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [ACC_W-1:0] acc_o
);
    AST_ONE_COIL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({coil_a_o != 2'b00, coil_b_o != 2'b00}) <= 1); // R2
    AST_NO_BOTH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (coil_a_o != 2'b11) && (coil_b_o != 2'b11)); // R2
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (coil_a_o == 2'b00) && (coil_b_o == 2'b00)); // R2
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !abort_i) |=> busy_o); // R1
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(acc_o)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !busy_o && !done_o); // R9
endmodule

bind stall_seq stall_seq_chk #(.ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .abort_i  (abort_i),
    .coil_a_o (coil_a_o),
    .coil_b_o (coil_b_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .acc_o    (acc_o)
);

// File: tb/stall_seq_tb.sv
module stall_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, abort_i = 1'b0;
    logic        coil_sel_i = 1'b0, pol_i = 1'b0, bit_i = 1'b0;
    logic [15:0] blank_cnt_i = '0, integ_cnt_i = '0, thresh_i = '0;
    logic [1:0]  coil_a_o, coil_b_o;
    logic        busy_o, done_o, stall_o;
    logic [15:0] acc_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stall_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .coil_sel_i(coil_sel_i), .pol_i(pol_i), .blank_cnt_i(blank_cnt_i),
        .integ_cnt_i(integ_cnt_i), .thresh_i(thresh_i), .bit_i(bit_i),
        .coil_a_o(coil_a_o), .coil_b_o(coil_b_o), .busy_o(busy_o),
        .done_o(done_o), .stall_o(stall_o), .acc_o(acc_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat_step(input int acc, input bit b);
        int n;
        n = b ? acc + 1 : acc - 1;
        if (n > 32767) n = 32767;
        if (n < -32768) n = -32768;
        return n;
    endfunction

    function automatic logic [1:0] exp_code(input bit active, input bit this_sel,
                                            input bit sel, input bit pol);
        if (!active || (this_sel != sel)) return 2'b00;
        return pol ? 2'b01 : 2'b10;
    endfunction

    // bmode: 0 random, 1 all ones, 2 all zeros; poke: cycle of a stray start (0 none)
    task automatic measure(input int b, input int n, input int thr, input bit sel,
                           input bit pol, input int bmode, input int poke,
                           input bit chain);
        int acc = 0;
        bit drv_bad = 0, tim_bad = 0, acc_bad = 0;
        logic [1:0] ea, eb;
        @(negedge clk);
        blank_cnt_i = 16'(b); integ_cnt_i = 16'(n); thresh_i = 16'(thr);
        coil_sel_i = sel; pol_i = pol; start_i = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= b + n + 3; k++) begin
            @(negedge clk);
            start_i = (k == poke);
            if (k == poke) begin
                coil_sel_i = ~sel; pol_i = ~pol; blank_cnt_i = 16'd0;
                integ_cnt_i = 16'd0; thresh_i = 16'(thr + 1000);
            end
            bit_i = (bmode == 1) ? 1'b1 : (bmode == 2) ? 1'b0 : 1'($urandom);
            ea = exp_code(k <= b + n + 2, 1'b0, sel, pol);
            eb = exp_code(k <= b + n + 2, 1'b1, sel, pol);
            if (coil_a_o !== ea || coil_b_o !== eb) drv_bad = 1;
            if (busy_o !== 1'b1 || done_o !== 1'b0) tim_bad = 1;
            if (k <= b + 2 && acc_o !== 16'd0) acc_bad = 1;
            @(posedge clk);
            if (k >= b + 2 && k <= b + n + 2) acc = sat_step(acc, bit_i);
        end
        @(negedge clk);
        start_i = 1'b0;
        check(!drv_bad, "R2", "coil drive codes during run", drv_bad, 0);
        check(!tim_bad, "R3", "busy high, done low through run", tim_bad, 0);
        check(!acc_bad, "R1", "accumulator cleared during blanking", acc_bad, 0);
        if (poke != 0) check(!drv_bad && !tim_bad, "R8", "stray start ignored", drv_bad | tim_bad, 0);
        check(done_o === 1'b1, "R3", "done at edge B+N+3", done_o, 1);
        check(busy_o === 1'b0, "R7", "busy low with done", busy_o, 0);
        check(int'($signed(acc_o)) == acc, (n > 32000) ? "R5" : "R4", "sum", int'($signed(acc_o)), acc);
        check(stall_o === (acc <= thr), "R6", "stall decision", stall_o, acc <= thr);
        if (chain) begin
            blank_cnt_i = 16'd0; integ_cnt_i = 16'd0; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o === 1'b1, "R1", "start during done accepted", busy_o, 1);
            for (int w = 0; w < 10 && busy_o; w++) @(negedge clk);
        end else begin
            @(negedge clk);
            check(done_o === 1'b0, "R7", "done is one cycle", done_o, 0);
            check(int'($signed(acc_o)) == acc, "R4", "sum held after run", int'($signed(acc_o)), acc);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_set;
        seed_set = $urandom(32'd7341);
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0, "R7", "reset idle", busy_o, 0);
        check(coil_a_o === 2'b00 && coil_b_o === 2'b00, "R2", "reset coils off", coil_a_o, 0);
        check(stall_o === 1'b0 && acc_o === 16'd0, "R6", "reset result", acc_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // equal threshold: 10 ones -> +10
        measure(3, 9, 10, 1'b0, 1'b1, 1, 0, 1'b0);
        measure(3, 9, 9, 1'b1, 1'b0, 1, 0, 1'b0);
        measure(0, 0, -1, 1'b1, 1'b1, 2, 0, 1'b0);
        // stray starts mid-run
        measure(4, 12, 0, 1'b0, 1'b0, 0, 2, 1'b0);
        measure(2, 8, 0, 1'b1, 1'b1, 0, 9, 1'b0);
        // random runs
        for (int r = 0; r < 6; r++)
            measure(int'($urandom_range(20)), int'($urandom_range(60)),
                    int'($urandom_range(40)) - 20, 1'($urandom), 1'($urandom), 0, 0, r == 5);
        // saturation
        measure(0, 33000, 100, 1'b0, 1'b1, 1, 0, 1'b0);
        measure(1, 33000, -32768, 1'b1, 1'b0, 2, 0, 1'b0);

        // abort mid-run
        @(negedge clk);
        blank_cnt_i = 16'd5; integ_cnt_i = 16'd20; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (8) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check(busy_o === 1'b0, "R9", "abort returns idle", busy_o, 0);
        check(coil_a_o === 2'b00 && coil_b_o === 2'b00, "R9", "abort coils off", {coil_a_o, coil_b_o}, 0);
        begin
            bit saw = 0;
            repeat (40) begin @(negedge clk); if (done_o) saw = 1; end
            check(!saw, "R9", "no done after abort", saw, 0);
        end
        // start and abort together
        start_i = 1'b1; abort_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; abort_i = 1'b0;
        check(busy_o === 1'b0, "R9", "abort beats start", busy_o, 0);
        @(negedge clk);
        check(busy_o === 1'b0 && coil_a_o === 2'b00, "R9", "still idle", busy_o, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule